// File: doc/BRIEF.md
# I2C Register Target Port

This block is an I2C target for a small byte-addressed register space. A fast system clock samples SCL and SDA, and the block pulls SDA low through an open-drain enable. Before any bus event is decoded, both lines pass through a synchronizer and a spike filter. The filter is on after reset. Software can switch it off by setting one bit of a control register, and that register lives in the same address space as every other register.

The target answers to a 7-bit bus address. The upper six bits are fixed at `001110`, and the lowest bit comes from the `addr_pin` input. The first byte after the address sets an internal register pointer.
- In a write, the next byte is presented on a parallel register interface together with a one-cycle write strobe.
- In a read, the master first writes the pointer and issues STOP. It then starts again with the read bit set, and the target shifts out one byte.

Addresses 00h and 01h return fixed identification bytes and cannot be written. All other addresses are served by the surrounding logic through `reg_addr` and `reg_rdata`.

Top module: `i2c_regport`

## Requirements
- R1: The target drives SDA low on the 9th SCL clock of the first byte after START only when the byte's upper seven bits equal `0011_10` followed by `addr_pin`. On a mismatch it drives nothing until the next START and produces no write strobe.
- R2: A write (START, address+W, register byte, data byte, STOP) is acknowledged on all three bytes. It produces exactly one `reg_wr` pulse, one cycle long, with `reg_addr` equal to the register byte and `reg_wdata` equal to the data byte.
- R3: A read works as follows. The master sends address+W and a register byte, then STOP, then START and address+R. The target then drives the value of `reg_rdata` for the pointed address, MSB first, over the next 8 SCL clocks, and changes SDA only while SCL is low.
- R4: Address 00h reads as 27h and address 01h reads as E0h, whatever `reg_rdata` holds.
- R5: A write to address 00h or 01h is acknowledged, but it produces no `reg_wr` pulse.
- R6: While the filter is on, a level change on SCL or SDA is accepted only after it has been sampled on 3 consecutive system clocks. An SCL high spike of 2 clocks inside a low phase is therefore ignored.
- R7: Bit 6 of register 10h set to 1 bypasses the filter, so a 2-clock SCL spike then counts as an extra clock. Writing 0 to that bit turns the filter back on. Writes to 10h still appear on `reg_wr`.
- R8: After the 8th bit of a read byte the target releases SDA. It then ignores further SCL clocks until STOP or START.
- R9: A START or STOP in the middle of a byte aborts the transfer and clears the bit count. A START begins a fresh address byte, and an aborted data byte produces no write strobe.
- R10: After reset, `sda_oe` is 0, `reg_wr` is 0, `reg_addr` is 00h and the filter is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_pin | input | 1 | Lowest bit of the 7-bit bus address |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to write, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` (combinational) |

## Verification
If the bit counter or state holds a wrong value, the fault appears on the bus within one byte. A missing or misplaced ACK shows on SDA at the 9th clock, and a shifted byte shows on `reg_wdata` or on the read data at the next strobe or read. A filter that passes spikes, or swallows valid edges, corrupts the byte in which the spike falls. That corruption is visible as a known wrong value (A5h becomes D2h) at the end of the same transfer. A pointer or identification fault shows on the first read after the pointer is written.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_BASE = 6'b001110;
  localparam logic [BYTE_W-1:0] ID_BYTE0 = 8'h27;
  localparam logic [BYTE_W-1:0] ID_BYTE1 = 8'hE0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_TXACK, ST_HOLD
  } rp_state_e;

  function automatic logic [6:0] target_addr(input logic pin);
    return {DEV_BASE, pin};
  endfunction

  function automatic logic is_id_addr(input logic [BYTE_W-1:0] a);
    return a[BYTE_W-1:1] == '0;
  endfunction

  function automatic logic [BYTE_W-1:0] id_value(input logic [BYTE_W-1:0] a);
    return a[0] ? ID_BYTE1 : ID_BYTE0;
  endfunction
endpackage

// File: rtl/i2c_rp_filter.sv
module i2c_rp_filter #(
  parameter int   SYNC_LEN = 2,
  parameter int   FILT_LEN = 3,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                filt_q;
  logic                samp;

  assign samp = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_LEN{IDLE_LVL}};
      hist_q <= {FILT_LEN{IDLE_LVL}};
      filt_q <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], samp};
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
    end
  end

  assign line_o = bypass ? samp : filt_q;

  AST_FILT_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(samp, 2) == filt_q && $past(samp, 4) == filt_q)); // R6
endmodule

// File: rtl/i2c_rp_events.sv
module i2c_rp_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_f;
      sda_prev_q <= sda_f;
    end
  end

  assign ev_start = scl_prev_q & scl_f & sda_prev_q & ~sda_f;
  assign ev_stop  = scl_prev_q & scl_f & ~sda_prev_q & sda_f;
  assign ev_rise  = ~scl_prev_q & scl_f;
  assign ev_fall  = scl_prev_q & ~scl_f;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              addr_pin,
  input  logic [BYTE_W-1:0] rd_val,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  rp_state_e         state_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, ptr_q, wd_q;
  logic              wr_q, oe_q;
  logic              byte_done, addr_hit;

  assign byte_done = ev_fall && (cnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (sh_q[BYTE_W-1:1] == target_addr(addr_pin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (ev_start) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (ev_stop) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_REG, ST_DATA: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (addr_hit) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                  nxt_q   <= sh_q[0] ? ST_TX : ST_REG;
                end else begin
                  state_q <= ST_HOLD;
                end
              end else if (state_q == ST_REG) begin
                ptr_q   <= sh_q;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                nxt_q   <= ST_DATA;
              end else begin
                wd_q    <= sh_q;
                wr_q    <= 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                nxt_q   <= ST_HOLD;
              end
            end
          end
          ST_ACK: begin
            if (ev_fall) begin
              state_q <= nxt_q;
              cnt_q   <= '0;
              if (nxt_q == ST_TX) begin
                tx_q <= rd_val;
                oe_q <= ~rd_val[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (ev_fall) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                oe_q    <= 1'b0;
                state_q <= ST_TXACK;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                tx_q  <= tx_q << 1;
                oe_q  <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (ev_rise) state_q <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign wdata_o  = wd_q;
  assign wr_o     = wr_q;
  assign sda_oe_o = oe_q;

  AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state_q == ST_DEV && cnt_q == '0)); // R9
  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD || state_q == ST_IDLE || state_q == ST_TXACK) |-> !sda_oe_o); // R8
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int               SYNC_LEN   = 2,
  parameter int               FILT_LEN   = 3,
  parameter logic [BYTE_W-1:0] CTRL_ADDR  = 8'h10,
  parameter int               BYPASS_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_pin,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic              scl_f, sda_f;
  logic              bypass_q;
  logic              ev_start, ev_stop, ev_rise, ev_fall;
  logic              wr_e;
  logic [BYTE_W-1:0] ptr, wdata, rd_val;

  assign raw_lines = {scl_i, sda_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2c_rp_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .bypass(bypass_q),
      .line_i(raw_lines[i]), .line_o(filt_lines[i]));
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_rp_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

  assign rd_val = is_id_addr(ptr) ? id_value(ptr) : reg_rdata;

  i2c_rp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_f(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .addr_pin(addr_pin), .rd_val(rd_val),
    .ptr_o(ptr), .wdata_o(wdata), .wr_o(wr_e), .sda_oe_o(sda_oe));

  assign reg_wr    = wr_e && !is_id_addr(ptr);
  assign reg_addr  = ptr;
  assign reg_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            bypass_q <= 1'b0;
    else if (reg_wr && ptr == CTRL_ADDR)   bypass_q <= wdata[BYPASS_BIT];
  end

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R2
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R3
  AST_WR_AFTER_ACKED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> sda_oe); // R2
endmodule

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
  localparam int Q = 25;
  localparam logic [6:0] DEV0 = 7'h1C;
  localparam logic [6:0] DEV1 = 7'h1D;
  localparam int NV = 11;
  // {read, register, write data, expected read}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h20, 8'h11, 8'h00},
    {1'b0, 8'h21, 8'hFE, 8'h00},
    {1'b1, 8'h20, 8'h00, 8'h11},
    {1'b1, 8'h21, 8'h00, 8'hFE},
    {1'b1, 8'h00, 8'h00, 8'h27},
    {1'b1, 8'h01, 8'h00, 8'hE0},
    {1'b0, 8'h00, 8'h55, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h27},
    {1'b0, 8'hFF, 8'h80, 8'h00},
    {1'b1, 8'hFF, 8'h00, 8'h80},
    {1'b1, 8'h77, 8'h00, 8'h2D}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, spike = 1'b0, pin = 1'b0;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] last_a, last_d;
  int wr_cnt;
  int total = 0, bad = 0;
  wire sda_line = sda_m & ~sda_oe;
  wire scl_line = scl_m | spike;

  always #5 clk = ~clk;

  i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pin(pin), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      wr_cnt <= 0; last_a <= 8'h00; last_d <= 8'h00;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
      last_a <= reg_addr;
      last_d <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, input bit spk, output logic got);
    sda_m = b;
    if (spk) begin
      waitq(10); spike = 1'b1; waitq(2); spike = 1'b0; waitq(Q - 12);
    end else waitq(Q);
    scl_m = 1'b1; waitq(Q);
    got = sda_line; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(2 * Q);
  endtask

  task automatic tx_byte(input logic [7:0] v, input bit spk, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(v[i], spk && i == 7, g);
    bit_io(1'b1, 1'b0, g);
    ack = !g;
  endtask

  task automatic rx_byte(input logic nack, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, 1'b0, g); v[i] = g; end
    bit_io(nack, 1'b0, g);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          input bit spk, output logic [2:0] acks);
    i2c_start();
    tx_byte({dev, 1'b0}, 1'b0, acks[2]);
    tx_byte(ra, 1'b0, acks[1]);
    tx_byte(d, spk, acks[0]);
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] ra,
                         output logic [7:0] d, output logic [2:0] acks);
    i2c_start();
    tx_byte({dev, 1'b0}, 1'b0, acks[2]);
    tx_byte(ra, 1'b0, acks[1]);
    i2c_stop();
    i2c_start();
    tx_byte({dev, 1'b1}, 1'b0, acks[0]);
    rx_byte(1'b1, d);
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic [7:0] d;
    logic g;
    int c0;
    waitq(20); rst_n = 1'b1; waitq(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk(reg_wr == 1'b0, "R10 reg_wr", {7'd0, reg_wr}, 8'h00);
    chk(reg_addr == 8'h00, "R10 reg_addr", reg_addr, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [24:0] v;
      v = VEC[k];
      if (v[24]) begin
        do_read(DEV0, v[23:16], d, acks);
        chk(acks == 3'b111, "R3 read acks", {5'd0, acks}, 8'h07);
        chk(d == v[7:0], (v[23:17] == 7'd0) ? "R4 id read" : "R3 read data", d, v[7:0]);
      end else begin
        c0 = wr_cnt;
        do_write(DEV0, v[23:16], v[15:8], 1'b0, acks);
        chk(acks == 3'b111, "R2 write acks", {5'd0, acks}, 8'h07);
        if (v[23:17] == 7'd0)
          chk(wr_cnt == c0, "R5 id write suppressed", 8'(wr_cnt - c0), 8'h00);
        else begin
          chk(wr_cnt == c0 + 1, "R2 one strobe", 8'(wr_cnt - c0), 8'h01);
          chk(last_a == v[23:16] && last_d == v[15:8], "R2 strobe data", last_d, v[15:8]);
        end
      end
    end

    // R1 address mismatch and pin-selected LSB
    c0 = wr_cnt;
    do_write(DEV1, 8'h50, 8'h3C, 1'b0, acks);
    chk(acks == 3'b000 && wr_cnt == c0, "R1 mismatch pin=0", {5'd0, acks}, 8'h00);
    pin = 1'b1; waitq(4);
    do_write(DEV1, 8'h50, 8'h3C, 1'b0, acks);
    chk(acks == 3'b111 && last_d == 8'h3C && last_a == 8'h50, "R1 match pin=1", last_d, 8'h3C);
    c0 = wr_cnt;
    do_write(DEV0, 8'h51, 8'h3C, 1'b0, acks);
    chk(acks[2] == 1'b0 && wr_cnt == c0, "R1 mismatch pin=1", {5'd0, acks}, 8'h00);
    pin = 1'b0; waitq(4);

    // R6 filter on: 2-clock SCL spike ignored
    do_write(DEV0, 8'h30, 8'hA5, 1'b1, acks);
    chk(last_a == 8'h30 && last_d == 8'hA5, "R6 spike filtered", last_d, 8'hA5);

    // R7 bypass: spike becomes an extra clock, {d7, d7..d1}
    do_write(DEV0, 8'h10, 8'h40, 1'b0, acks);
    chk(last_a == 8'h10 && last_d == 8'h40, "R7 control write on strobe", last_d, 8'h40);
    do_write(DEV0, 8'h31, 8'hA5, 1'b1, acks);
    chk(last_a == 8'h31 && last_d == 8'hD2, "R7 spike passes bypass", last_d, 8'hD2);
    do_write(DEV0, 8'h10, 8'h00, 1'b0, acks);
    do_write(DEV0, 8'h32, 8'h3C, 1'b1, acks);
    chk(last_a == 8'h32 && last_d == 8'h3C, "R7 filter restored", last_d, 8'h3C);

    // R8 release after read byte, ignore clocks until STOP
    i2c_start();
    tx_byte({DEV0, 1'b0}, 1'b0, acks[2]);
    tx_byte(8'h20, 1'b0, acks[1]);
    i2c_stop();
    i2c_start();
    tx_byte({DEV0, 1'b1}, 1'b0, acks[0]);
    rx_byte(1'b1, d);
    chk(d == 8'h11, "R8 read byte", d, 8'h11);
    rx_byte(1'b1, d);
    chk(d == 8'hFF && sda_oe == 1'b0, "R8 released after NACK", d, 8'hFF);
    i2c_stop();

    // R9 START mid-byte restarts address phase
    c0 = wr_cnt;
    i2c_start();
    for (int i = 7; i >= 4; i--) bit_io(DEV0[i - 1], 1'b0, g);
    i2c_start();
    tx_byte({DEV0, 1'b0}, 1'b0, acks[2]);
    tx_byte(8'h40, 1'b0, acks[1]);
    tx_byte(8'h5A, 1'b0, acks[0]);
    i2c_stop();
    chk(acks == 3'b111 && wr_cnt == c0 + 1 && last_d == 8'h5A, "R9 restart mid-byte", last_d, 8'h5A);
    // R9 STOP mid data byte: no strobe
    c0 = wr_cnt;
    i2c_start();
    tx_byte({DEV0, 1'b0}, 1'b0, acks[2]);
    tx_byte(8'h41, 1'b0, acks[1]);
    for (int i = 0; i < 3; i++) bit_io(1'b1, 1'b0, g);
    i2c_stop();
    chk(wr_cnt == c0 && sda_oe == 1'b0, "R9 stop mid-byte", 8'(wr_cnt - c0), 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule